// File: doc/BRIEF.md
# Static LCD Segment Driver Core

This block is the digital core of a static (one common plane, 1:1 duty) liquid-crystal driver for forty segments. A host sends display bits over three wires: serial data, a data clock and a load strobe. Each rising edge of the data clock moves one bit into a forty-bit shift register. A rising edge of the load strobe copies that register into a forty-bit display register. Only the display register controls what the glass shows. The last stage of the shift register drives a serial output. Two or three cores can therefore share one data clock and one load strobe and act as a single chain of 80 or 120 segments.

The core makes its waveforms from an externally selected display clock. Both common outputs carry the inverse of that clock. An "on" segment toggles in anti-phase with the commons, and an "off" segment toggles in phase with them. Active-low enables can hold each common output low. Two more active-low enables hold the lower sixteen segments and the upper twenty-four segments low. A blink gate, paced by its own blink clock, turns the whole pattern off during the high half of that clock.

A binary divider runs from the nominal 32 kHz input clock. It produces eight taps, five for the display clock and three for the blink clock. The board chooses which taps to route back into the display clock and blink clock inputs.

Top module: `static_lcd_core`

## Requirements
- R1: The serial data is sampled on each rising edge of `ser_clk`. The first bit of a forty-bit word belongs to segment 40 and the last bit belongs to segment 1. After the load, segment n (output `seg[n-1]`) shows the bit sent in position 41-n.
- R2: The display pattern changes only on a rising edge of `ser_load`. Shifting new bits without a load leaves every segment output unchanged.
- R3: After each `ser_clk` rising edge, `ser_dout` equals the bit that was sampled 40 rising edges earlier, counting that bit's own edge as the first.
- R4: While `rst_n` is low, the shift register, the display register and the divider are all cleared. Every segment then shows its off waveform, `ser_dout` is 0 and every divider tap is 0.
- R5: `com_a` and `com_b` each equal the inverse of `lcd_clk`. An output whose own enable (`com_a_en_n`, `com_b_en_n`) is 1 is held at 0, and the other common output is unaffected.
- R6: With the blink gate closed, an enabled segment whose display bit is 1 outputs `lcd_clk`, and one whose bit is 0 outputs the inverse of `lcd_clk`.
- R7: When `seg_lo_en_n` is 1, `seg[15:0]` is 0. When `seg_hi_en_n` is 1, `seg[39:16]` is 0. Each group enable affects only its own group.
- R8: When `blink_en_n` is 0 and `blink_clk` is 1, every enabled segment outputs the inverse of `lcd_clk`, whatever its display bit. When `blink_clk` is 0, or when `blink_en_n` is 1, the stored pattern is shown and `blink_clk` has no effect.
- R9: After reset is released, `div_taps[i]` toggles every D/2 rising edges of `fin` and first rises after D/2 edges. D is 16, 32, 64, 128, 256, 8192, 16384 and 32768 for i = 0 to 7. The divider wraps after 32768 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| ser_clk | input | 1 | Serial data clock, rising edge shifts |
| ser_din | input | 1 | Serial display data |
| ser_load | input | 1 | Load strobe, rising edge updates the display |
| ser_dout | output | 1 | Chain output to the next core's data input |
| fin | input | 1 | Divider input clock, nominally 32 kHz |
| div_taps | output | 8 | Divided clocks, slowest in bit 7 |
| lcd_clk | input | 1 | Display clock (one of taps 0 to 4 on the board) |
| blink_clk | input | 1 | Blink pacing clock |
| blink_en_n | input | 1 | Active-low blink enable |
| seg_lo_en_n | input | 1 | Active-low enable for segments 1 to 16 |
| seg_hi_en_n | input | 1 | Active-low enable for segments 17 to 40 |
| com_a_en_n | input | 1 | Active-low enable for `com_a` |
| com_b_en_n | input | 1 | Active-low enable for `com_b` |
| com_a | output | 1 | Common plane waveform A |
| com_b | output | 1 | Common plane waveform B |
| seg | output | 40 | Segment waveforms, bit 0 is segment 1 |

## Verification
The segment and common outputs are combinational from the display register and the clock, blink and enable inputs, so they settle in the same time step as their inputs. The bench changes these inputs on a falling edge of `fin` and samples one time unit later. The display register changes at the load rising edge, so the bench samples the outputs only after the strobe. `ser_dout` moves one stage per `ser_clk` rising edge, and the bench reads it after that clock's falling edge. The divider taps are registered on each `fin` rising edge. The bench compares them on every falling edge against a count of edges it keeps itself.

// File: rtl/slcd_pkg.sv
package slcd_pkg;
  localparam int SEG_COUNT = 40;
  localparam int LOW_GROUP = 16;
  localparam int DIV_WIDTH = 15;
  localparam int TAP_COUNT = 8;

  // counter bit that carries tap idx (divide by 2^(bit+1))
  function automatic int tap_bit(input int idx);
    case (idx)
      0: return 3;
      1: return 4;
      2: return 5;
      3: return 6;
      4: return 7;
      5: return 12;
      6: return 13;
      default: return 14;
    endcase
  endfunction

  // waveform of one segment: off_n kills it, lit and not blanked follows lck
  function automatic logic seg_drive(input logic lit, input logic lck,
                                     input logic blank, input logic off_n);
    if (off_n) return 1'b0;
    return (lit && !blank) ? lck : !lck;
  endfunction
endpackage

// File: rtl/slcd_shift.sv
module slcd_shift #(
  parameter int W = 40
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         dout
);
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= {word[W-2:0], din};
  end

  assign dout = word[W-1];
endmodule

// File: rtl/slcd_latch.sv
module slcd_latch #(
  parameter int W = 40
) (
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge load or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/slcd_divider.sv
module slcd_divider
  import slcd_pkg::*;
#(
  parameter int CW = DIV_WIDTH,
  parameter int NT = TAP_COUNT
) (
  input  logic          rst_n,
  input  logic          fin,
  output logic [NT-1:0] taps
);
  logic [CW-1:0] cnt;

  always_ff @(posedge fin or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tap
    assign taps[i] = cnt[tap_bit(i)];
  end
endmodule

// File: rtl/slcd_wave.sv
module slcd_wave
  import slcd_pkg::*;
#(
  parameter int W  = SEG_COUNT,
  parameter int LO = LOW_GROUP
) (
  input  logic [W-1:0] disp,
  input  logic         lck,
  input  logic         bclk,
  input  logic         blink_en_n,
  input  logic         lo_en_n,
  input  logic         hi_en_n,
  input  logic         ca_en_n,
  input  logic         cb_en_n,
  output logic [W-1:0] seg,
  output logic         com_a,
  output logic         com_b,
  output logic         blank
);
  assign blank = !blink_en_n && bclk;
  assign com_a = !ca_en_n && !lck;
  assign com_b = !cb_en_n && !lck;

  for (genvar i = 0; i < W; i++) begin : g_seg
    if (i < LO) begin : g_lo
      assign seg[i] = seg_drive(disp[i], lck, blank, lo_en_n);
    end else begin : g_hi
      assign seg[i] = seg_drive(disp[i], lck, blank, hi_en_n);
    end
  end
endmodule

// File: rtl/static_lcd_core.sv
module static_lcd_core
  import slcd_pkg::*;
#(
  parameter int NSEG = SEG_COUNT,
  parameter int NLOW = LOW_GROUP,
  parameter int DIVW = DIV_WIDTH,
  parameter int NTAP = TAP_COUNT
) (
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            ser_din,
  input  logic            ser_load,
  output logic            ser_dout,
  input  logic            fin,
  output logic [NTAP-1:0] div_taps,
  input  logic            lcd_clk,
  input  logic            blink_clk,
  input  logic            blink_en_n,
  input  logic            seg_lo_en_n,
  input  logic            seg_hi_en_n,
  input  logic            com_a_en_n,
  input  logic            com_b_en_n,
  output logic            com_a,
  output logic            com_b,
  output logic [NSEG-1:0] seg
);
  logic [NSEG-1:0] shift_word;
  logic [NSEG-1:0] disp_word;
  logic            seg_blank;

  slcd_shift #(.W(NSEG)) u_shift (
    .rst_n(rst_n), .sclk(ser_clk), .din(ser_din),
    .word(shift_word), .dout(ser_dout)
  );

  slcd_latch #(.W(NSEG)) u_latch (
    .rst_n(rst_n), .load(ser_load), .d(shift_word), .q(disp_word)
  );

  slcd_divider #(.CW(DIVW), .NT(NTAP)) u_div (
    .rst_n(rst_n), .fin(fin), .taps(div_taps)
  );

  slcd_wave #(.W(NSEG), .LO(NLOW)) u_wave (
    .disp(disp_word), .lck(lcd_clk), .bclk(blink_clk),
    .blink_en_n(blink_en_n), .lo_en_n(seg_lo_en_n), .hi_en_n(seg_hi_en_n),
    .ca_en_n(com_a_en_n), .cb_en_n(com_b_en_n),
    .seg(seg), .com_a(com_a), .com_b(com_b), .blank(seg_blank)
  );
endmodule

// File: rtl/slcd_core_chk.sv
module slcd_core_chk #(
  parameter int W  = 40,
  parameter int LO = 16,
  parameter int NT = 8
) (
  input logic          rst_n,
  input logic          ser_clk,
  input logic          ser_din,
  input logic          ser_load,
  input logic          ser_dout,
  input logic          fin,
  input logic [NT-1:0] div_taps,
  input logic          blink_clk,
  input logic          blink_en_n,
  input logic          seg_lo_en_n,
  input logic          seg_hi_en_n,
  input logic          com_a_en_n,
  input logic          com_b_en_n,
  input logic          com_a,
  input logic          com_b,
  input logic [W-1:0]  seg,
  input logic [W-1:0]  shift_word,
  input logic [W-1:0]  disp_word,
  input logic          seg_blank
);
  localparam int HI = W - LO;

  logic fin_seen;
  logic sclk_seen;

  always_ff @(posedge fin or negedge rst_n) begin
    if (!rst_n) fin_seen <= 1'b0;
    else        fin_seen <= 1'b1;
  end

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) sclk_seen <= 1'b0;
    else        sclk_seen <= 1'b1;
  end

  // R1
  din_capture_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    sclk_seen |-> shift_word[0] == $past(ser_din));

  // R3
  dout_delay_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    sclk_seen |-> ser_dout == $past(shift_word[W-2]));

  // R2
  disp_hold_chk: assert property (@(posedge fin) disable iff (!rst_n)
    (fin_seen && !$rose(ser_load)) |-> $stable(disp_word));

  // R4
  reset_clear_chk: assert property (@(posedge fin)
    !rst_n |-> (shift_word == '0 && disp_word == '0 && div_taps == '0));

  // R5
  com_match_chk: assert property (@(posedge fin) disable iff (!rst_n)
    (!com_a_en_n && !com_b_en_n) |-> com_a == com_b);

  // R5
  com_a_off_chk: assert property (@(posedge fin) disable iff (!rst_n)
    com_a_en_n |-> !com_a);

  // R5
  com_b_off_chk: assert property (@(posedge fin) disable iff (!rst_n)
    com_b_en_n |-> !com_b);

  // R7
  seg_lo_off_chk: assert property (@(posedge fin) disable iff (!rst_n)
    seg_lo_en_n |-> seg[LO-1:0] == '0);

  // R7
  seg_hi_off_chk: assert property (@(posedge fin) disable iff (!rst_n)
    seg_hi_en_n |-> seg[W-1:LO] == '0);

  // R6
  seg_lo_phase_chk: assert property (@(posedge fin) disable iff (!rst_n)
    (!com_a_en_n && !seg_lo_en_n && (blink_en_n || !blink_clk))
      |-> (seg[LO-1:0] ^ {LO{com_a}}) == disp_word[LO-1:0]);

  // R6
  seg_hi_phase_chk: assert property (@(posedge fin) disable iff (!rst_n)
    (!com_b_en_n && !seg_hi_en_n && !seg_blank)
      |-> (seg[W-1:LO] ^ {HI{com_b}}) == disp_word[W-1:LO]);

  // R8
  blink_off_chk: assert property (@(posedge fin) disable iff (!rst_n)
    (!blink_en_n && blink_clk && !com_a_en_n && !seg_hi_en_n)
      |-> seg[W-1:LO] == {HI{com_a}});

  // R9
  for (genvar i = 0; i + 1 < NT; i++) begin : g_chain
    if (i != 4) begin : g_pair
      tap_chain_chk: assert property (@(posedge fin) disable iff (!rst_n)
        (fin_seen && !$stable(div_taps[i+1])) |-> $fell(div_taps[i]));
    end
  end
endmodule

bind static_lcd_core slcd_core_chk #(.W(NSEG), .LO(NLOW), .NT(NTAP)) u_chk (
  .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .ser_load(ser_load),
  .ser_dout(ser_dout), .fin(fin), .div_taps(div_taps),
  .blink_clk(blink_clk), .blink_en_n(blink_en_n),
  .seg_lo_en_n(seg_lo_en_n), .seg_hi_en_n(seg_hi_en_n),
  .com_a_en_n(com_a_en_n), .com_b_en_n(com_b_en_n),
  .com_a(com_a), .com_b(com_b), .seg(seg),
  .shift_word(shift_word), .disp_word(disp_word), .seg_blank(seg_blank)
);

// File: tb/static_lcd_core_bench.sv
module static_lcd_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 40;
  localparam logic [1:0] M_LOW = 2'd0, M_SHOW = 2'd1, M_BLANK = 2'd2;
  localparam int DIVS [8] = '{16, 32, 64, 128, 256, 8192, 16384, 32768};
  localparam logic [39:0] PAT_A = 40'hA5_3C_F0_96_01;
  localparam logic [39:0] PAT_B = 40'h5A_C3_0F_69_FE;

  // {lck, bck, blink_en_n, lo_n, hi_n, ca_n, cb_n, exp_ca, exp_cb, mode_lo, mode_hi}
  localparam int NVEC = 12;
  localparam logic [12:0] VEC [NVEC] = '{
    {7'b0010000, 2'b11, M_SHOW,  M_SHOW },
    {7'b1010000, 2'b00, M_SHOW,  M_SHOW },
    {7'b1110000, 2'b00, M_SHOW,  M_SHOW },
    {7'b0100000, 2'b11, M_BLANK, M_BLANK},
    {7'b1100000, 2'b00, M_BLANK, M_BLANK},
    {7'b1000000, 2'b00, M_SHOW,  M_SHOW },
    {7'b0011000, 2'b11, M_LOW,   M_SHOW },
    {7'b1010100, 2'b00, M_SHOW,  M_LOW  },
    {7'b0011110, 2'b01, M_LOW,   M_LOW  },
    {7'b0010001, 2'b10, M_SHOW,  M_SHOW },
    {7'b1101011, 2'b00, M_LOW,   M_BLANK},
    {7'b0100100, 2'b11, M_BLANK, M_LOW  }
  };

  logic rst_n = 1'b1;
  logic fin = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0;
  logic lcd_clk = 1'b0, blink_clk = 1'b0, blink_en_n = 1'b1;
  logic seg_lo_en_n = 1'b0, seg_hi_en_n = 1'b0;
  logic com_a_en_n = 1'b0, com_b_en_n = 1'b0;
  logic ser_dout, com_a, com_b;
  logic [7:0] div_taps;
  logic [NSEG-1:0] seg;

  int n_tests = 0, n_fail = 0;
  int fin_edges = 0, div_err = 0;
  bit tap7_high = 1'b0, done = 1'b0;

  static_lcd_core u_static_lcd_core (
    .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .ser_load(ser_load),
    .ser_dout(ser_dout), .fin(fin), .div_taps(div_taps), .lcd_clk(lcd_clk),
    .blink_clk(blink_clk), .blink_en_n(blink_en_n),
    .seg_lo_en_n(seg_lo_en_n), .seg_hi_en_n(seg_hi_en_n),
    .com_a_en_n(com_a_en_n), .com_b_en_n(com_b_en_n),
    .com_a(com_a), .com_b(com_b), .seg(seg)
  );

  always #(CLK_PERIOD / 2) fin = ~fin;

  // independent divider model: edge count since reset release
  always @(posedge fin) if (rst_n) fin_edges <= fin_edges + 1;

  always @(negedge fin) begin
    if (rst_n) begin
      for (int i = 0; i < 8; i++) begin
        if (div_taps[i] != (((fin_edges % 32768) / (DIVS[i] / 2)) % 2 == 1))
          div_err++;
      end
      if (div_taps[7]) tap7_high = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NSEG-1:0] exp_seg(input logic [NSEG-1:0] w, input logic lck,
                                              input logic [1:0] mlo, input logic [1:0] mhi);
    logic [NSEG-1:0] r;
    for (int i = 0; i < NSEG; i++) begin
      logic [1:0] m;
      m = (i < 16) ? mlo : mhi;
      if (m == M_LOW)       r[i] = 1'b0;
      else if (m == M_SHOW) r[i] = w[i] ? lck : !lck;
      else                  r[i] = !lck;
    end
    return r;
  endfunction

  task automatic shift_bit(input logic b);
    @(negedge fin);
    ser_din = b;
    #1 ser_clk = 1'b1;
    #2 ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [NSEG-1:0] w);
    for (int i = NSEG - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_load();
    @(negedge fin) ser_load = 1'b1;
    repeat (2) @(negedge fin);
    ser_load = 1'b0;
    repeat (2) @(negedge fin);
  endtask

  task automatic set_lck(input logic l);
    @(negedge fin) lcd_clk = l;
    #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [79:0] stream;
    int dout_bad;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge fin);
    #1;
    // R4: reset state, all segments off (in phase with commons)
    check(seg == {NSEG{1'b1}}, "R4 seg off in reset", seg, {NSEG{1'b1}});
    check(ser_dout == 1'b0 && div_taps == 8'h00, "R4 dout and taps cleared",
          {ser_dout, div_taps}, 0);
    check(com_a && com_b, "R5 commons invert lcd_clk in reset", {com_a, com_b}, 2'b11);
    @(negedge fin) rst_n = 1'b1;

    // R2: shifting without load leaves display alone
    send_word(PAT_A);
    set_lck(1'b1);
    check(seg == '0, "R2 no change before load", seg, 0);
    pulse_load();
    #1;
    // R1: ordering seg40 first, segment n shows bit for seg n
    check(seg == PAT_A, "R1 pattern mapping lck=1", seg, PAT_A);
    set_lck(1'b0);
    check(seg == ~PAT_A, "R6 pattern lck=0", seg, ~PAT_A);

    // R5 R6 R7 R8: table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [NSEG-1:0] e;
      @(negedge fin);
      {lcd_clk, blink_clk, blink_en_n, seg_lo_en_n, seg_hi_en_n,
       com_a_en_n, com_b_en_n} = VEC[v][12:6];
      #1;
      e = exp_seg(PAT_A, VEC[v][12], VEC[v][3:2], VEC[v][1:0]);
      check({com_a, com_b} == VEC[v][5:4], "R5 common outputs", {com_a, com_b}, VEC[v][5:4]);
      check(seg == e, "R6 R7 R8 segment outputs", seg, e);
    end
    @(negedge fin);
    {lcd_clk, blink_clk, blink_en_n, seg_lo_en_n, seg_hi_en_n, com_a_en_n, com_b_en_n} = 7'b0010000;

    // R3: chain output delay across an 80-bit stream
    stream = {PAT_B, PAT_A};
    dout_bad = 0;
    for (int n = 0; n < 80; n++) begin
      shift_bit(stream[79 - n]);
      #1;
      if (n >= 39 && ser_dout != stream[79 - (n - 39)]) dout_bad++;
    end
    check(dout_bad == 0, "R3 dout delayed by 40 edges", dout_bad, 0);
    check(ser_dout == PAT_A[39], "R3 dout holds first bit of second word", ser_dout, PAT_A[39]);
    // R2: display still from the earlier load
    set_lck(1'b1);
    check(seg == PAT_A, "R2 display held while shifting", seg, PAT_A);
    pulse_load();
    #1;
    check(seg == PAT_A, "R1 last forty bits displayed", seg, PAT_A);

    // R9: divider taps over a full wrap
    while (fin_edges < 34000) @(negedge fin);
    check(div_err == 0, "R9 divider tap mismatches", div_err, 0);
    check(tap7_high, "R9 slowest tap reached high", tap7_high, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule